// File: doc/BRIEF.md
# Programmable Serial Transceiver

This block sends and receives asynchronous serial characters on one transmit line and one receive line. A processor reaches it through four byte-wide locations. These are a data location, a status location, a frame-setup location and a bit-rate divisor. Transmit uses a single holding register in front of the shifter. Receive uses a single result register.

Every character is framed the same way. The line rests high. A low start bit comes first, then the data bits least significant first, then an optional parity bit, then a high stop period. Software can change the character length, the parity mode and the stop length at any time. Each side captures the setup when a character begins. The receiver runs a 16x oversampling clock. It confirms a start bit at half a bit time and takes each later bit near its centre.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, status reads 0x01, frame setup reads 0x03 (8 data bits, no parity, one stop bit), the divisor reads the reset parameter value, and the transmit line is high.
- R2: Each access is a request held until acknowledge. Acknowledge is a one-cycle pulse in the clock cycle after the request is first seen. Read data is valid while acknowledge is high. Address 0 is data, 1 is status, 2 is frame setup and 3 is the divisor.
- R3: A transmitted character is one low start bit, then the data bits least significant first, then the optional parity bit, then a high stop period. A character sent out and looped back is received unchanged.
- R4: Frame setup bits [1:0] give the character length minus 5, so 5 to 8 data bits. Received data is right-aligned and its unused upper bits read 0.
- R5: Setup bit 2 enables parity. Setup bit 3 selects even parity when 1 and odd parity when 0. The parity bit follows the last data bit.
- R6: Setup bits [5:4] give the stop length: 0 is one bit, 1 is one and a half bits (24 ticks), and 2 or 3 is two bits. When characters go out back to back, the start bits are ((1+n+p)*16 + stop ticks)*(divisor+1) clocks apart.
- R7: One bit lasts 16*(divisor+1) clocks. The transmit line changes only on an oversample tick.
- R8: Status bits are: bit 0 transmit-ready (holding register empty), bit 1 receive-ready, bit 2 parity error, bit 3 framing error and bit 4 overrun. Bits 7:5 read 0.
- R9: A data write made while transmit-ready is 0 is dropped. The queued character is kept and the dropped one is never sent.
- R10: A received parity bit that does not match sets the parity error flag. A stop bit sampled low sets the framing error flag. The character is delivered in both cases.
- R11: A character that completes while receive-ready is 1 is discarded. The earlier data is kept and the overrun flag is set.
- R12: Reading the data location clears receive-ready, parity error, framing error and overrun.
- R13: A low pulse on the receive line shorter than half a bit time is ignored and produces no character. A longer one is taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until acknowledge |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_addr_i | input | 2 | Location select |
| cpu_wdata_i | input | 8 | Write data |
| cpu_ack_o | output | 1 | One-cycle acknowledge |
| cpu_rdata_o | output | 8 | Read data, valid with acknowledge |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
The bench builds the block with the default parameters: a 16x oversample, two synchronizer stages and strict start checking. It sets the divisor to 1, so one bit lasts 32 clocks. At that rate all 36 combinations of character length, parity mode and stop length can be swept with two back-to-back characters each. Every bit slot and the start-to-start spacing are predicted arithmetically. The bench also drives the receive line directly to inject bad parity, a low stop bit and start pulses on either side of the half-bit limit. It finishes with one run at divisor 3 to confirm the bit time scales with the divisor.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

   // Frame setup register layout, most significant field first
   typedef struct packed {
      logic [1:0] stop_code;   // 0: 1 bit, 1: 1.5 bits, 2/3: 2 bits
      logic       par_even;    // 1 even, 0 odd
      logic       par_en;      // parity bit present
      logic [1:0] len_code;    // data bits minus 5
   } frame_cfg_t;

   localparam frame_cfg_t CFG_RESET = '{stop_code: 2'd0, par_even: 1'b0,
                                        par_en: 1'b0, len_code: 2'd3};

   function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] len_code);
      logic [7:0] m;
      for (int i = 0; i < 8; i++) begin
         m[i] = (i <= int'(len_code) + 4);
      end
      return d & m;
   endfunction

   function automatic logic frame_parity(input logic [7:0] d, input logic [1:0] len_code,
                                         input logic par_even);
      return (^mask_data(d, len_code)) ^ ~par_even;
   endfunction

endpackage

// File: rtl/uart_xcvr_baud.sv
module uart_xcvr_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   generate
      if (DIV_W < 1) begin : g_bad_div_w
         $error("uart_xcvr_baud: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= div_i;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
   import uart_xcvr_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  frame_cfg_t cfg_i,
   input  logic       load_valid_i,
   input  logic [7:0] load_data_i,
   output logic       load_take_o,
   output logic       txd_o
);

   localparam int CW = $clog2(2 * OSR + 1);
   localparam logic [CW-1:0] SLOT_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] STOP1_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] STOP15_LAST = CW'(OSR + OSR / 2 - 1);
   localparam logic [CW-1:0] STOP2_LAST = CW'(2 * OSR - 1);

   typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;

   tx_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    idx_q;
   logic [7:0]    sh_q;
   logic          par_q;
   logic [1:0]    len_q;
   logic          pen_q;
   logic [1:0]    stop_q;
   logic [CW-1:0] stop_last;
   logic          slot_end;
   logic          stop_end;

   always_comb begin
      case (stop_q)
         2'd0:    stop_last = STOP1_LAST;
         2'd1:    stop_last = STOP15_LAST;
         default: stop_last = STOP2_LAST;
      endcase
   end

   assign slot_end = (cnt_q == SLOT_LAST);
   assign stop_end = (cnt_q == stop_last);
   assign load_take_o = tick_i & load_valid_i &
                        ((state_q == TX_IDLE) | ((state_q == TX_STOP) & stop_end));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= TX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         par_q   <= 1'b0;
         len_q   <= '0;
         pen_q   <= 1'b0;
         stop_q  <= '0;
      end else if (tick_i) begin
         if (load_take_o) begin
            state_q <= TX_START;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= load_data_i;
            par_q   <= frame_parity(load_data_i, cfg_i.len_code, cfg_i.par_even);
            len_q   <= cfg_i.len_code;
            pen_q   <= cfg_i.par_en;
            stop_q  <= cfg_i.stop_code;
         end else begin
            unique case (state_q)
               TX_IDLE: ;
               TX_START: begin
                  if (slot_end) begin
                     state_q <= TX_DATA;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               TX_DATA: begin
                  if (slot_end) begin
                     cnt_q <= '0;
                     sh_q  <= {1'b0, sh_q[7:1]};
                     if (idx_q == 3'(len_q) + 3'd4) begin
                        idx_q   <= '0;
                        state_q <= pen_q ? TX_PAR : TX_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               TX_PAR: begin
                  if (slot_end) begin
                     state_q <= TX_STOP;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               TX_STOP: begin
                  if (stop_end) begin
                     state_q <= TX_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= TX_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (state_q)
         TX_START: txd_o = 1'b0;
         TX_DATA:  txd_o = sh_q[0];
         TX_PAR:   txd_o = par_q;
         default:  txd_o = 1'b1;
      endcase
   end

   // R7: the line may only move on an oversample tick
   a_r7_line_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(txd_o));

   // R3: a new character always opens with a low start bit
   a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_take_o |=> !txd_o);

endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
   import uart_xcvr_pkg::*;
#(
   parameter int OSR          = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit STRICT_START = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  frame_cfg_t cfg_i,
   input  logic       rxd_i,
   output logic       done_o,
   output logic [7:0] data_o,
   output logic       par_err_o,
   output logic       frm_err_o
);

   localparam int CW = $clog2(2 * OSR + 1);
   localparam logic [CW-1:0] SLOT_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_xcvr_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;
   logic                   early_abort;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      end
   end
   assign rxs = sync_q[SYNC_STAGES-1];

   // Start qualification: strict drops on any high tick, loose only looks at mid-bit
   generate
      if (STRICT_START) begin : g_strict
         assign early_abort = rxs;
      end else begin : g_loose
         assign early_abort = 1'b0;
      end
   endgenerate

   rx_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    idx_q;
   logic [7:0]    sh_q;
   logic          par_rx_q;
   frame_cfg_t    cfg_q;
   logic          slot_end;

   assign slot_end = (cnt_q == SLOT_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         sh_q      <= '0;
         par_rx_q  <= 1'b0;
         cfg_q     <= CFG_RESET;
         done_o    <= 1'b0;
         data_o    <= '0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (!rxs) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                     sh_q    <= '0;
                     cfg_q   <= cfg_i;
                  end
               end
               RX_START: begin
                  if (cnt_q == MID_LAST) begin
                     cnt_q   <= '0;
                     idx_q   <= '0;
                     state_q <= rxs ? RX_IDLE : RX_DATA;
                  end else if (early_abort) begin
                     state_q <= RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (slot_end) begin
                     cnt_q       <= '0;
                     sh_q[idx_q] <= rxs;
                     if (idx_q == 3'(cfg_q.len_code) + 3'd4) begin
                        idx_q   <= '0;
                        state_q <= cfg_q.par_en ? RX_PAR : RX_STOP;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (slot_end) begin
                     cnt_q    <= '0;
                     par_rx_q <= rxs;
                     state_q  <= RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (slot_end) begin
                     cnt_q     <= '0;
                     state_q   <= RX_IDLE;
                     done_o    <= 1'b1;
                     data_o    <= sh_q;
                     frm_err_o <= !rxs;
                     par_err_o <= cfg_q.par_en &
                                  (par_rx_q != frame_parity(sh_q, cfg_q.len_code, cfg_q.par_even));
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R3: completion is a single-cycle event
   a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10: a parity error is never reported while parity is off for that character
   a_r10_no_parity_err_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !cfg_q.par_en) |-> !par_err_o);

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
   import uart_xcvr_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter int DIV_RESET    = 10,
   parameter int OSR          = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit STRICT_START = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cpu_req_i,
   input  logic       cpu_we_i,
   input  logic [1:0] cpu_addr_i,
   input  logic [7:0] cpu_wdata_i,
   output logic       cpu_ack_o,
   output logic [7:0] cpu_rdata_o,
   output logic       txd_o,
   input  logic       rxd_i
);

   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_CFG  = 2'd2;
   localparam logic [1:0] A_DIV  = 2'd3;

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div_w
         $error("uart_xcvr: DIV_W must be 1..8");
      end
      if (DIV_RESET < 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_div_reset
         $error("uart_xcvr: DIV_RESET must fit in DIV_W bits");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_xcvr: OSR must be even and at least 4");
      end
   endgenerate

   logic             acc, wr_data, rd_data, wr_cfg, wr_div;
   logic             tick, tx_take, rx_done, rx_perr, rx_ferr;
   logic [7:0]       rx_word;
   logic [7:0]       hold_q, rx_data_q;
   logic             hold_full_q, rx_ready_q, perr_q, ferr_q, ovr_q;
   logic [DIV_W-1:0] div_q;
   frame_cfg_t       cfg_q;
   logic [7:0]       status;

   assign acc     = cpu_req_i & ~cpu_ack_o;
   assign wr_data = acc & cpu_we_i & (cpu_addr_i == A_DATA);
   assign rd_data = acc & ~cpu_we_i & (cpu_addr_i == A_DATA);
   assign wr_cfg  = acc & cpu_we_i & (cpu_addr_i == A_CFG);
   assign wr_div  = acc & cpu_we_i & (cpu_addr_i == A_DIV);
   assign status  = {3'b000, ovr_q, ferr_q, perr_q, rx_ready_q, ~hold_full_q};

   uart_xcvr_baud #(.DIV_W(DIV_W)) baud_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .div_i (div_q),
      .tick_o(tick)
   );

   uart_xcvr_tx #(.OSR(OSR)) tx_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .cfg_i       (cfg_q),
      .load_valid_i(hold_full_q),
      .load_data_i (hold_q),
      .load_take_o (tx_take),
      .txd_o       (txd_o)
   );

   uart_xcvr_rx #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES), .STRICT_START(STRICT_START)) rx_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cfg_i    (cfg_q),
      .rxd_i    (rxd_i),
      .done_o   (rx_done),
      .data_o   (rx_word),
      .par_err_o(rx_perr),
      .frm_err_o(rx_ferr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cpu_ack_o   <= 1'b0;
         cpu_rdata_o <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         rx_data_q   <= '0;
         rx_ready_q  <= 1'b0;
         perr_q      <= 1'b0;
         ferr_q      <= 1'b0;
         ovr_q       <= 1'b0;
         div_q       <= DIV_W'(DIV_RESET);
         cfg_q       <= CFG_RESET;
      end else begin
         cpu_ack_o <= acc;
         if (acc && !cpu_we_i) begin
            case (cpu_addr_i)
               A_DATA:  cpu_rdata_o <= rx_data_q;
               A_STAT:  cpu_rdata_o <= status;
               A_CFG:   cpu_rdata_o <= {2'b00, cfg_q};
               default: cpu_rdata_o <= 8'(div_q);
            endcase
         end
         if (wr_cfg) cfg_q <= frame_cfg_t'(cpu_wdata_i[5:0]);
         if (wr_div) div_q <= cpu_wdata_i[DIV_W-1:0];
         if (tx_take) hold_full_q <= 1'b0;
         if (wr_data && !hold_full_q) begin
            hold_q      <= cpu_wdata_i;
            hold_full_q <= 1'b1;
         end
         if (rd_data) begin
            rx_ready_q <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            ovr_q      <= 1'b0;
         end
         if (rx_done) begin
            if (rx_ready_q && !rd_data) begin
               ovr_q <= 1'b1;
            end else begin
               rx_data_q  <= rx_word;
               perr_q     <= rx_perr;
               ferr_q     <= rx_ferr;
               rx_ready_q <= 1'b1;
            end
         end
      end
   end

   // R2: acknowledge is one cycle wide and follows a fresh request
   a_r2_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_ack_o |=> !cpu_ack_o);
   a_r2_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_req_i && !cpu_ack_o) |=> cpu_ack_o);

   // R9: a write into a full holding register leaves it untouched
   a_r9_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_data && hold_full_q && !tx_take) |=> (hold_full_q && $stable(hold_q)));

   // R11: a character arriving on top of unread data keeps the old data
   a_r11_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_done && rx_ready_q && !rd_data) |=> (ovr_q && $stable(rx_data_q)));

   // R12: reading data clears the receive flags
   a_r12_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data && !rx_done) |=> (!rx_ready_q && !ovr_q && !perr_q && !ferr_q));

endmodule

// File: tb/uart_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_xcvr_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic       ack;
   logic [7:0] rdata;
   logic       txd;
   logic       rxd;
   logic       loop_en = 1'b1;
   logic       line = 1'b1;

   int checks = 0;
   int errors = 0;
   int ack_late = 0;
   int div_now = 10;
   bit done = 1'b0;

   always #2 clk = ~clk;
   assign rxd = loop_en ? txd : line;

   uart_xcvr dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cpu_req_i  (req),
      .cpu_we_i   (we),
      .cpu_addr_i (addr),
      .cpu_wdata_i(wdata),
      .cpu_ack_o  (ack),
      .cpu_rdata_o(rdata),
      .txd_o      (txd),
      .rxd_i      (rxd)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus(input bit w, input logic [1:0] a, input logic [7:0] d,
                      output logic [7:0] q);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      if (!ack) ack_late++;
      while (!ack) @(negedge clk);
      q = rdata;
      req = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      logic [7:0] q;
      bus(1'b1, a, d, q);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] q);
      bus(1'b0, a, 8'd0, q);
   endtask

   task automatic wait_rx(output logic [7:0] st);
      for (int i = 0; i < 4000; i++) begin
         rd(2'd1, st);
         if (st[1]) break;
      end
   endtask

   task automatic wait_tx_ready();
      logic [7:0] st;
      for (int i = 0; i < 4000; i++) begin
         rd(2'd1, st);
         if (st[0]) break;
      end
   endtask

   // Bench-driven serial frame, bit time follows the current divisor
   task automatic drive_frame(input logic [7:0] d, input int nbits, input bit pen,
                              input bit pval, input bit stop_ok);
      int bt;
      bt = 16 * (div_now + 1);
      @(negedge clk);
      line = 1'b0;
      repeat (bt) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         line = d[i];
         repeat (bt) @(negedge clk);
      end
      if (pen) begin
         line = pval;
         repeat (bt) @(negedge clk);
      end
      if (stop_ok) begin
         line = 1'b1;
      end else begin
         line = 1'b0;
         repeat (12 * (div_now + 1)) @(negedge clk);
         line = 1'b1;
      end
      repeat (2 * bt) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] q, st;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(txd == 1'b1, "R1 line idle high", txd, 1);
      rd(2'd1, q); chk(q == 8'h01, "R1 status", q, 8'h01);
      rd(2'd2, q); chk(q == 8'h03, "R1 setup", q, 8'h03);
      rd(2'd3, q); chk(q == 8'd10, "R1 divisor", q, 10);

      wr(2'd3, 8'd1); div_now = 1;
      rd(2'd3, q); chk(q == 8'd1, "R7 divisor readback", q, 1);

      // R3 R4 R5 R6: sweep every length, parity mode and stop length
      for (int l = 0; l < 4; l++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int sc = 0; sc < 3; sc++) begin
               int n, pen, stop_t, frame, pos, bad;
               logic [7:0] a, b, msk, ctl;
               logic pbit;
               n = 5 + l;
               pen = (pm != 0) ? 1 : 0;
               stop_t = (sc == 0) ? 16 : ((sc == 1) ? 24 : 32);
               frame = ((1 + n + pen) * 16 + stop_t) * 2;
               msk = 8'((1 << n) - 1);
               a = 8'(8'h5A + l * 37 + pm * 11 + sc * 3);
               b = ~a;
               pbit = (^(a & msk)) ^ (pm == 1);
               ctl = {2'b00, 2'(sc), (pm == 2), (pm != 0), 2'(l)};
               wr(2'd2, ctl);
               bad = 0;
               fork
                  begin
                     wr(2'd0, a);
                     wait_tx_ready();
                     wr(2'd0, b);
                  end
                  begin
                     do @(negedge clk); while (txd != 1'b0);
                     pos = 0;
                     for (int s = 1; s <= n + pen; s++) begin
                        int tgt;
                        logic expb;
                        tgt = s * 32 + 16;
                        repeat (tgt - pos) @(negedge clk);
                        pos = tgt;
                        expb = (s <= n) ? a[s-1] : pbit;
                        if (txd != expb) bad++;
                     end
                     repeat (frame - 1 - pos) @(negedge clk);
                     chk(txd == 1'b1, "R6 stop still high", txd, 1);
                     @(negedge clk);
                     chk(txd == 1'b0, "R6 next start on time", txd, 0);
                  end
               join
               chk(bad == 0, "R3 R5 serial bit slots", bad, 0);
               wait_rx(st);
               chk((st & 8'h1E) == 8'h02, "R8 status after first char", st, 8'h02);
               rd(2'd0, q);
               chk(q == (a & msk), "R4 first char", q, a & msk);
               wait_rx(st);
               rd(2'd0, q);
               chk(q == (b & msk), "R4 second char", q, b & msk);
            end
         end
      end
      wr(2'd2, 8'h03);
      repeat (400) @(negedge clk);

      // R9: write into a full holding register is dropped
      wr(2'd0, 8'h11);
      wait_tx_ready();
      wr(2'd0, 8'h22);
      rd(2'd1, q); chk(q[0] == 1'b0, "R9 holding full", q[0], 0);
      wr(2'd0, 8'h33);
      wait_rx(st); rd(2'd0, q); chk(q == 8'h11, "R9 first kept", q, 8'h11);
      wait_rx(st); rd(2'd0, q); chk(q == 8'h22, "R9 queued kept", q, 8'h22);
      repeat (1000) @(negedge clk);
      rd(2'd1, q); chk(q == 8'h01, "R9 dropped char never sent", q, 8'h01);

      // R11 R12: overrun
      wr(2'd0, 8'hC3);
      wait_tx_ready();
      wr(2'd0, 8'h3C);
      repeat (800) @(negedge clk);
      rd(2'd1, q); chk(q == 8'h13, "R11 overrun status", q, 8'h13);
      rd(2'd0, q); chk(q == 8'hC3, "R11 old data kept", q, 8'hC3);
      rd(2'd1, q); chk(q == 8'h01, "R12 flags cleared by read", q, 8'h01);

      // R10: parity error, even parity, 8 bits
      loop_en = 1'b0;
      wr(2'd2, 8'h0F);
      drive_frame(8'h3C, 8, 1'b1, 1'b1, 1'b1);
      wait_rx(st);
      chk((st & 8'h1E) == 8'h06, "R10 parity error flag", st, 8'h06);
      rd(2'd0, q); chk(q == 8'h3C, "R10 data with parity error", q, 8'h3C);
      rd(2'd1, q); chk(q == 8'h01, "R12 parity flag cleared", q, 8'h01);
      drive_frame(8'h3C, 8, 1'b1, 1'b0, 1'b1);
      wait_rx(st);
      chk((st & 8'h1E) == 8'h02, "R5 good even parity", st, 8'h02);
      rd(2'd0, q);

      // R10: framing error, 8N1
      wr(2'd2, 8'h03);
      drive_frame(8'h81, 8, 1'b0, 1'b0, 1'b0);
      wait_rx(st);
      chk((st & 8'h1E) == 8'h0A, "R10 framing error flag", st, 8'h0A);
      rd(2'd0, q); chk(q == 8'h81, "R10 data with framing error", q, 8'h81);
      rd(2'd1, q); chk(q == 8'h01, "R12 framing flag cleared", q, 8'h01);

      // R13: short low pulse rejected, longer accepted
      @(negedge clk); line = 1'b0;
      repeat (12) @(negedge clk); line = 1'b1;
      repeat (700) @(negedge clk);
      rd(2'd1, q); chk(q == 8'h01, "R13 glitch ignored", q, 8'h01);
      @(negedge clk); line = 1'b0;
      repeat (24) @(negedge clk); line = 1'b1;
      wait_rx(st);
      chk((st & 8'h1E) == 8'h02, "R13 long pulse accepted", st, 8'h02);
      rd(2'd0, q); chk(q == 8'hFF, "R13 all-ones char", q, 8'hFF);

      // R7: bit time at divisor 3
      loop_en = 1'b1;
      wr(2'd3, 8'd3); div_now = 3;
      repeat (100) @(negedge clk);
      wr(2'd0, 8'h01);
      do @(negedge clk); while (txd != 1'b0);
      repeat (63) @(negedge clk);
      chk(txd == 1'b0, "R7 start lasts 64 clocks", txd, 0);
      @(negedge clk);
      chk(txd == 1'b1, "R7 bit0 after 64 clocks", txd, 1);
      wait_rx(st); rd(2'd0, q); chk(q == 8'h01, "R7 loopback at divisor 3", q, 8'h01);

      chk(ack_late == 0, "R2 ack one cycle after request", ack_late, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule